// File: doc/BRIEF.md
# Interrupt Delivery Gate with NMI Blocking

This block sits between an interrupt controller and a processor core and decides, every clock, whether a waiting interrupt is handed to the core. It handles two kinds of request.

A non-maskable request always gets through unless the gate is already inside a non-maskable handler. A hidden blocking latch records that state. The latch is released by any interrupt-return the core completes, even one that finishes a nested exception handler and not the non-maskable one itself.

A vectored maskable request from the controller gets through only when all three of these hold:
- the core's interrupt-enable flag is set;
- the vector's priority class (its upper four bits) is strictly above a task priority threshold;
- no non-maskable delivery wins the same cycle.

The threshold is written by software and is never touched by deliveries. The gate acknowledges each maskable delivery to the controller. It also forwards the core's end-of-interrupt command to the controller, but only while an external interrupt is in service. Non-maskable deliveries need no end-of-interrupt.

Top module: `intDeliveryGate`

## Requirements
- R1: After reset, deliver, deliverNmi, intAck and eoiOut are 0, deliverVec is 0, ieFlag is 0, tprValue is 0, nmiBlocked is 0, and no non-maskable event is pending.
- R2: A non-maskable request sampled on a clock edge while nmiBlocked is 0 is delivered whatever the value of ieFlag. On the following cycle, deliver=1, deliverNmi=1 and deliverVec=NMI_VEC (default 2).
- R3: A non-maskable delivery sets nmiBlocked. While nmiBlocked is 1, no non-maskable delivery occurs. Any number of requests arriving while blocked collapse into one pending event.
- R4: An iretDone pulse clears nmiBlocked on that edge. A pending non-maskable event is then delivered on the next edge.
- R5: A maskable request (intReq level) is delivered only when ieFlag=1 and intVector[7:4] > tprValue (strictly; equal does not qualify). A delivery shows deliver=1, deliverNmi=0, deliverVec=intVector and a one-cycle intAck=1. deliverVec is 0 in every cycle without a delivery.
- R6: A maskable delivery clears ieFlag on the same edge. This overrides an ieWrEn write on that edge. Otherwise, ieWrEn loads ieWrVal.
- R7: When a non-maskable and a maskable request are both eligible on the same edge, only the non-maskable one is delivered. The maskable one stays waiting for a later edge.
- R8: tprValue changes only on a tprWrEn edge, where it loads tprWrVal. Deliveries leave it unchanged.
- R9: eoiReq produces a one-cycle eoiOut pulse on the next cycle only while a maskable interrupt is in service (delivered and not yet ended). Otherwise eoiReq is ignored. Non-maskable deliveries never put an interrupt in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiReq | input | 1 | Non-maskable request pulse |
| intReq | input | 1 | Maskable request level from controller |
| intVector | input | 8 | Vector number of the maskable request |
| ieWrEn | input | 1 | Write strobe for the interrupt-enable flag |
| ieWrVal | input | 1 | Value written to the interrupt-enable flag |
| tprWrEn | input | 1 | Write strobe for the task priority threshold |
| tprWrVal | input | 4 | Value written to the threshold |
| iretDone | input | 1 | Pulse: the core completed an interrupt-return |
| eoiReq | input | 1 | Pulse: the core ends an external handler |
| deliver | output | 1 | Delivery strobe to the core |
| deliverNmi | output | 1 | Delivery is the non-maskable one |
| deliverVec | output | 8 | Delivered vector number |
| intAck | output | 1 | Acknowledge of a maskable delivery to the controller |
| eoiOut | output | 1 | End-of-interrupt pulse to the controller |
| ieFlag | output | 1 | Current interrupt-enable flag |
| tprValue | output | 4 | Current task priority threshold |
| nmiBlocked | output | 1 | Inside-non-maskable blocking state |

## Verification
The assertions assume that nmiReq, iretDone and eoiReq are single-cycle pulses driven between edges. They also assume that intVector is stable whenever intReq is high on an edge, so that the delivered vector is the one that passed the class test.

The stimulus drives every input just after the falling edge. It holds intVector with intReq inside each directed case. In the random phase, both are redrawn together every cycle, so each edge sees one consistent pair. Random phases mix returns, enable writes and threshold writes freely, so that blocked requests, equal-class boundaries and write-versus-clear collisions occur without being scripted.

// File: rtl/gateTypes_pkg.sv
package gateTypes_pkg;
  // Strobes from control to datapath, one clock edge each
  typedef struct packed {
    logic nmiGo;   // non-maskable delivery this edge
    logic maskGo;  // maskable delivery this edge
    logic eoiGo;   // forward end-of-interrupt this edge
  } gateStrobes_t;
endpackage

// File: rtl/intGateCtl.sv
module intGateCtl
  import gateTypes_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         nmiReq,
  input  logic         intReq,
  input  logic         ieFlag,
  input  logic         classOk,
  input  logic         iretDone,
  input  logic         eoiReq,
  output gateStrobes_t strobes,
  output logic         nmiBlocked
);
  logic nmiPend;
  logic inService;
  logic nmiAvail;

  always_comb begin
    nmiAvail       = nmiPend | nmiReq;
    strobes.nmiGo  = nmiAvail & ~nmiBlocked;
    strobes.maskGo = ~strobes.nmiGo & intReq & ieFlag & classOk;
    strobes.eoiGo  = eoiReq & inService;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPend    <= 1'b0;
      nmiBlocked <= 1'b0;
      inService  <= 1'b0;
    end else begin
      nmiPend <= nmiAvail & ~strobes.nmiGo;
      if (strobes.nmiGo)      nmiBlocked <= 1'b1;
      else if (iretDone)      nmiBlocked <= 1'b0;
      if (strobes.maskGo)     inService <= 1'b1;
      else if (eoiReq)        inService <= 1'b0;
    end
  end

  // R3
  nmi_not_when_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiBlocked |-> !strobes.nmiGo);
  // R3
  nmi_sets_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nmiGo |=> nmiBlocked);
  // R3
  blocked_req_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && nmiBlocked) |=> nmiPend);
  // R4
  iret_unblocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iretDone && !strobes.nmiGo) |=> !nmiBlocked);
  // R9
  eoi_needs_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.eoiGo |-> inService);
endmodule

// File: rtl/intGateDp.sv
module intGateDp
  import gateTypes_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'(2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobes_t     strobes,
  input  logic [VEC_W-1:0] intVector,
  input  logic             ieWrEn,
  input  logic             ieWrVal,
  input  logic             tprWrEn,
  input  logic [CLS_W-1:0] tprWrVal,
  output logic             classOk,
  output logic             ieFlag,
  output logic [CLS_W-1:0] tprValue,
  output logic             deliver,
  output logic             deliverNmi,
  output logic [VEC_W-1:0] deliverVec,
  output logic             intAck,
  output logic             eoiOut
);
  localparam int CLS_MSB = VEC_W - 1;

  always_comb classOk = intVector[CLS_MSB -: CLS_W] > tprValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieFlag     <= 1'b0;
      tprValue   <= '0;
      deliver    <= 1'b0;
      deliverNmi <= 1'b0;
      deliverVec <= '0;
      intAck     <= 1'b0;
      eoiOut     <= 1'b0;
    end else begin
      if (strobes.maskGo)  ieFlag <= 1'b0;
      else if (ieWrEn)     ieFlag <= ieWrVal;
      if (tprWrEn)         tprValue <= tprWrVal;
      deliver    <= strobes.nmiGo | strobes.maskGo;
      deliverNmi <= strobes.nmiGo;
      if (strobes.nmiGo)       deliverVec <= NMI_VEC;
      else if (strobes.maskGo) deliverVec <= intVector;
      else                     deliverVec <= '0;
      intAck     <= strobes.maskGo;
      eoiOut     <= strobes.eoiGo;
    end
  end

  // R5
  mask_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> (deliverVec[CLS_MSB -: CLS_W] > $past(tprValue)) && $past(ieFlag));
  // R6
  mask_clears_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> !ieFlag);
  // R7
  single_delivery_chk: assert property (@(posedge clk) disable iff (!rstN)
    deliverNmi |-> !intAck);
  // R8
  tpr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tprWrEn |=> $stable(tprValue));
endmodule

// File: rtl/intDeliveryGate.sv
module intDeliveryGate
  import gateTypes_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'(2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiReq,
  input  logic             intReq,
  input  logic [VEC_W-1:0] intVector,
  input  logic             ieWrEn,
  input  logic             ieWrVal,
  input  logic             tprWrEn,
  input  logic [CLS_W-1:0] tprWrVal,
  input  logic             iretDone,
  input  logic             eoiReq,
  output logic             deliver,
  output logic             deliverNmi,
  output logic [VEC_W-1:0] deliverVec,
  output logic             intAck,
  output logic             eoiOut,
  output logic             ieFlag,
  output logic [CLS_W-1:0] tprValue,
  output logic             nmiBlocked
);
  gateStrobes_t strobes;
  logic         classOk;

  intGateCtl uCtl (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .intReq(intReq),
    .ieFlag(ieFlag), .classOk(classOk), .iretDone(iretDone),
    .eoiReq(eoiReq), .strobes(strobes), .nmiBlocked(nmiBlocked)
  );

  intGateDp #(.VEC_W(VEC_W), .CLS_W(CLS_W), .NMI_VEC(NMI_VEC)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .intVector(intVector),
    .ieWrEn(ieWrEn), .ieWrVal(ieWrVal), .tprWrEn(tprWrEn),
    .tprWrVal(tprWrVal), .classOk(classOk), .ieFlag(ieFlag),
    .tprValue(tprValue), .deliver(deliver), .deliverNmi(deliverNmi),
    .deliverVec(deliverVec), .intAck(intAck), .eoiOut(eoiOut)
  );
endmodule

// File: tb/sim_intDeliveryGate.sv
module sim_intDeliveryGate;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, nmiReq, intReq, ieWrEn, ieWrVal, tprWrEn, iretDone, eoiReq;
  logic [7:0] intVector;
  logic [3:0] tprWrVal;
  logic deliver, deliverNmi, intAck, eoiOut, ieFlag, nmiBlocked;
  logic [7:0] deliverVec;
  logic [3:0] tprValue;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  intDeliveryGate u0 (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .intReq(intReq),
    .intVector(intVector), .ieWrEn(ieWrEn), .ieWrVal(ieWrVal),
    .tprWrEn(tprWrEn), .tprWrVal(tprWrVal), .iretDone(iretDone),
    .eoiReq(eoiReq), .deliver(deliver), .deliverNmi(deliverNmi),
    .deliverVec(deliverVec), .intAck(intAck), .eoiOut(eoiOut),
    .ieFlag(ieFlag), .tprValue(tprValue), .nmiBlocked(nmiBlocked)
  );

  // Behavioural reference built from the requirements
  logic mIe, mBlk, mPend, mSvc, mDel, mNmi, mAck, mEoi;
  logic [7:0] mVec;
  logic [3:0] mTpr;
  bit nmiWins, maskWins;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIe = 0; mBlk = 0; mPend = 0; mSvc = 0; mDel = 0; mNmi = 0;
      mAck = 0; mEoi = 0; mVec = 0; mTpr = 0;
    end else begin
      nmiWins  = (mPend || nmiReq) && !mBlk;
      maskWins = !nmiWins && intReq && mIe && (intVector[7:4] > mTpr);
      mEoi  = eoiReq && mSvc;
      mDel  = nmiWins || maskWins;
      mNmi  = nmiWins;
      mAck  = maskWins;
      mVec  = nmiWins ? 8'd2 : (maskWins ? intVector : 8'd0);
      mPend = (mPend || nmiReq) && !nmiWins;
      if (nmiWins) mBlk = 1; else if (iretDone) mBlk = 0;
      if (maskWins) mIe = 0; else if (ieWrEn) mIe = ieWrVal;
      if (tprWrEn) mTpr = tprWrVal;
      if (maskWins) mSvc = 1; else if (eoiReq) mSvc = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 deliverNmi", 32'(deliverNmi), 32'(mNmi));
      chk("R5 deliver", 32'(deliver), 32'(mDel));
      chk("R5 deliverVec", 32'(deliverVec), 32'(mVec));
      chk("R5 intAck", 32'(intAck), 32'(mAck));
      chk("R3 nmiBlocked", 32'(nmiBlocked), 32'(mBlk));
      chk("R6 ieFlag", 32'(ieFlag), 32'(mIe));
      chk("R8 tprValue", 32'(tprValue), 32'(mTpr));
      chk("R9 eoiOut", 32'(eoiOut), 32'(mEoi));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulseNmi();
    nmiReq = 1; @(negedge clk); nmiReq = 0;
  endtask
  task automatic pulseIret();
    iretDone = 1; @(negedge clk); iretDone = 0;
  endtask

  initial begin
    rstN = 0; nmiReq = 0; intReq = 0; intVector = 0; ieWrEn = 0; ieWrVal = 0;
    tprWrEn = 0; tprWrVal = 0; iretDone = 0; eoiReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 deliver", 32'(deliver), 0);
    chk("R1 ieFlag", 32'(ieFlag), 0);
    chk("R1 tprValue", 32'(tprValue), 0);
    chk("R1 nmiBlocked", 32'(nmiBlocked), 0);
    chk("R1 deliverVec", 32'(deliverVec), 0);
    @(negedge clk);

    // R2: NMI with enable flag clear
    pulseNmi();
    chk("R2 nmi delivered", 32'(deliverNmi), 1);
    chk("R2 nmi vector", 32'(deliverVec), 2);
    // R3: two requests while blocked collapse into one
    pulseNmi();
    chk("R3 blocked no delivery", 32'(deliver), 0);
    pulseNmi();
    chk("R3 blocked no delivery again", 32'(deliver), 0);
    // R4: return unblocks, pending delivered next edge
    pulseIret();
    chk("R4 unblocked", 32'(nmiBlocked), 0);
    @(negedge clk);
    chk("R4 pending nmi delivered", 32'(deliverNmi), 1);
    pulseIret();
    @(negedge clk);
    chk("R3 single pending only", 32'(deliver), 0);

    // R5: class threshold boundary
    tprWrEn = 1; tprWrVal = 4'd3; ieWrEn = 1; ieWrVal = 1;
    @(negedge clk);
    tprWrEn = 0; ieWrEn = 0;
    intReq = 1; intVector = 8'h3A;
    @(negedge clk);
    chk("R5 equal class refused", 32'(deliver), 0);
    intVector = 8'h41;
    @(negedge clk);
    intReq = 0;
    chk("R5 higher class delivered", 32'(deliverVec), 32'h41);
    chk("R5 ack", 32'(intAck), 1);
    chk("R6 ie cleared", 32'(ieFlag), 0);
    chk("R8 tpr kept", 32'(tprValue), 3);
    // R9: end-of-interrupt forwarded once
    eoiReq = 1; @(negedge clk); eoiReq = 0;
    chk("R9 eoi forwarded", 32'(eoiOut), 1);
    eoiReq = 1; @(negedge clk); eoiReq = 0;
    chk("R9 stray eoi ignored", 32'(eoiOut), 0);

    // R6: delivery clear beats a same-edge write of 1
    ieWrEn = 1; ieWrVal = 1; @(negedge clk);
    intReq = 1; intVector = 8'h50;
    @(negedge clk);
    intReq = 0; ieWrEn = 0;
    chk("R6 clear wins over write", 32'(ieFlag), 0);
    eoiReq = 1; @(negedge clk); eoiReq = 0;

    // R9: NMI needs no end-of-interrupt
    pulseNmi();
    eoiReq = 1; @(negedge clk); eoiReq = 0;
    chk("R9 no eoi after nmi", 32'(eoiOut), 0);
    pulseIret();

    // R7: NMI wins, maskable follows
    ieWrEn = 1; ieWrVal = 1; @(negedge clk); ieWrEn = 0;
    nmiReq = 1; intReq = 1; intVector = 8'h90;
    @(negedge clk);
    nmiReq = 0;
    chk("R7 nmi first", 32'(deliverNmi), 1);
    chk("R7 maskable held", 32'(intAck), 0);
    @(negedge clk);
    intReq = 0;
    chk("R7 maskable next", 32'(intAck), 1);
    chk("R7 maskable vector", 32'(deliverVec), 32'h90);
    pulseIret();

    // Random mix, compared against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      nmiReq    = ($urandom % 16) == 0;
      intReq    = ($urandom % 3) == 0;
      intVector = 8'($urandom);
      ieWrEn    = ($urandom % 8) == 0;
      ieWrVal   = 1'($urandom);
      tprWrEn   = ($urandom % 20) == 0;
      tprWrVal  = 4'($urandom);
      iretDone  = ($urandom % 10) == 0;
      eoiReq    = ($urandom % 6) == 0;
      @(negedge clk);
    end
    nmiReq = 0; intReq = 0; ieWrEn = 0; tprWrEn = 0; iretDone = 0; eoiReq = 0;
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule